// File: doc/BRIEF.md
# Programmable Read Latency Pipeline

This block reproduces the read-return timing of a double-data-rate memory device. A configuration write delivers a mode word whose three-bit latency field selects a column latency of 3 to 6 clocks, together with a separate posted-delay value of 0 to 4 clocks. After that, one command is presented per clock: a READ or a no-operation. Every accepted READ returns a four-beat burst. The burst starts exactly posted-delay plus column-latency clocks after the clock edge that registered the READ. Each clock carries two beats, one for the rising edge and one for the falling edge, and the block presents them as a pair.

The beat words are derived from the address given with the READ, so the timing and the ordering of every burst can be seen from outside. The delay line can hold several reads in flight at the same time. This lets READs issued every second clock come out as one continuous stream of beats, in issue order. Illegal latency codes, out-of-range posted delays, configuration changes while reads are in flight, and READs that arrive too close to the previous one are all refused. Each refusal raises a one-clock error pulse.

Top module: `rd_lat_pipe`

## Requirements
- R1: After a synchronous reset, `dq_valid` and `req_err` are 0, and the effective latency is column latency 3 with posted delay 0.
- R2: The column latency field sits in `mode_word[6:4]`. Codes 3'b011, 3'b100, 3'b101 and 3'b110 select 3, 4, 5 and 6 clocks. A READ sampled at edge n shows its first beat pair in the cycle after edge n+AL+CL.
- R3: A configuration write with a field code of 0, 1, 2 or 7 leaves the column latency unchanged.
- R4: `mode_al` accepts 0 to 4. A written value above 4 leaves the posted delay unchanged, while a legal column latency code in the same write still takes effect.
- R5: A burst for address A lasts two consecutive cycles. The first cycle shows rise=A and fall=A+1. The second shows rise=A+2 and fall=A+3, with all sums taken modulo 2^16. `dq_valid` is 0 in every other cycle.
- R6: READs issued every two clocks produce back-to-back bursts in issue order, with no idle cycle between them.
- R7: A READ sampled one clock after an accepted READ is dropped and produces no burst.
- R8: A configuration write is ignored when a read is in flight. A read is in flight while a READ is in the delay line, while a burst has its second cycle pending, or when a READ is sampled in the same cycle as the write.
- R9: `req_err` is 1 for exactly the one cycle after the edge at which a refused event was sampled. Refused events are a reserved code, a posted delay above 4, a busy write, or a dropped READ. Otherwise `req_err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Configuration write strobe |
| mode_word | input | 13 | Mode word; column latency code in bits 6:4 |
| mode_al | input | 3 | Posted delay value written with `mode_wr` |
| cmd_rd | input | 1 | 1 = READ this clock, 0 = no-operation |
| rd_addr | input | 16 | Start address of the READ |
| dq_valid | output | 1 | Beat pair valid |
| dq_rise | output | 16 | Rising-edge beat |
| dq_fall | output | 16 | Falling-edge beat |
| req_err | output | 1 | One-cycle pulse for a refused write or dropped READ |

## Verification
A wrong latency register or a wrong tap selection moves the whole burst by one or more cycles. That shift appears at `dq_valid` in the cycle after edge n+AL+CL, at the latest at the first READ after the configuration changes. A corrupted token in the delay line or a wrong tail address shows up as a wrong `dq_rise` or `dq_fall` word within the two burst cycles. A wrong busy or refusal decision shows up either as a missing or spurious `req_err` pulse one cycle after the event, or as a shifted latency on the next READ.

// File: rtl/rlp_pkg.sv
package rlp_pkg;

    localparam int ADDR_W     = 16;
    localparam int MODE_W     = 13;
    localparam int CL_LSB     = 4;
    localparam int CL_CODE_W  = 3;
    localparam int AL_W       = 3;
    localparam int CL_MIN     = 3;
    localparam int CL_MAX     = 6;
    localparam int AL_MAX     = 4;
    localparam int LAT_MAX    = AL_MAX + CL_MAX;
    localparam int LAT_W      = $clog2(LAT_MAX + 1);
    localparam int CL_W       = $clog2(CL_MAX + 1);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } rd_tok_t;

    typedef struct packed {
        logic [CL_W-1:0] cl;
        logic [AL_W-1:0] al;
    } lat_cfg_t;

    typedef enum logic [0:0] {
        BG_IDLE = 1'b0,
        BG_TAIL = 1'b1
    } beat_st_t;

    function automatic logic cl_code_ok(input logic [CL_CODE_W-1:0] code);
        return (int'(code) >= CL_MIN) && (int'(code) <= CL_MAX);
    endfunction

    function automatic logic al_ok(input logic [AL_W-1:0] al);
        return int'(al) <= AL_MAX;
    endfunction

    function automatic logic [LAT_W-1:0] lat_total(input lat_cfg_t cfg);
        return LAT_W'(cfg.cl) + LAT_W'(cfg.al);
    endfunction

endpackage

// File: rtl/rlp_mode_reg.sv
module rlp_mode_reg
    import rlp_pkg::*;
#(
    parameter int DEF_CL = 3,
    parameter int DEF_AL = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [CL_CODE_W-1:0] cl_code,
    input  logic [AL_W-1:0]      al_in,
    input  logic                 busy,
    output lat_cfg_t             cfg,
    output logic                 rej
);

    logic code_good;
    logic al_good;

    assign code_good = cl_code_ok(cl_code);
    assign al_good   = al_ok(al_in);
    assign rej       = wr && (busy || !code_good || !al_good);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.cl <= CL_W'(DEF_CL);
            cfg.al <= AL_W'(DEF_AL);
        end else if (wr && !busy) begin
            if (code_good) cfg.cl <= CL_W'(cl_code);
            if (al_good)   cfg.al <= al_in;
        end
    end

    assert_cl_legal_R2: assert property (@(posedge clk) disable iff (rst)
        (int'(cfg.cl) >= CL_MIN) && (int'(cfg.cl) <= CL_MAX));

    assert_al_range_R4: assert property (@(posedge clk) disable iff (rst)
        int'(cfg.al) <= AL_MAX);

    assert_reserved_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && !code_good) |=> $stable(cfg.cl));

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (wr && busy) |=> $stable(cfg));

endmodule

// File: rtl/rlp_delay_line.sv
module rlp_delay_line
    import rlp_pkg::*;
#(
    parameter int DEPTH = LAT_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LAT_W-1:0]  tap_sel,
    output rd_tok_t           tap,
    output logic              head_vld,
    output logic              any_vld
);

    rd_tok_t            stg [DEPTH];
    logic [DEPTH-1:0]   vld_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg[0] <= '0;
        end else begin
            stg[0].vld  <= push;
            stg[0].addr <= addr;
        end
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end

        assert_gap_R7: assert property (@(posedge clk) disable iff (rst)
            !(stg[i].vld && stg[i-1].vld));
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_vld
        assign vld_vec[i] = stg[i].vld;
    end

    always_comb begin
        tap = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (tap_sel == LAT_W'(i + 1)) tap = stg[i];
        end
    end

    assign head_vld = stg[0].vld;
    assign any_vld  = |vld_vec;

    assert_push_lands_R2: assert property (@(posedge clk) disable iff (rst)
        push |=> (stg[0].vld && stg[0].addr == $past(addr)));

endmodule

// File: rtl/rlp_burst_gen.sv
module rlp_burst_gen
    import rlp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rd_tok_t           tap,
    output logic              dq_valid,
    output logic [ADDR_W-1:0] dq_rise,
    output logic [ADDR_W-1:0] dq_fall,
    output logic              pend
);

    beat_st_t          st;
    logic [ADDR_W-1:0] tail_base;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= BG_IDLE;
            tail_base <= '0;
            dq_valid  <= 1'b0;
            dq_rise   <= '0;
            dq_fall   <= '0;
        end else if (tap.vld) begin
            st        <= BG_TAIL;
            tail_base <= ADDR_W'(tap.addr + 2);
            dq_valid  <= 1'b1;
            dq_rise   <= tap.addr;
            dq_fall   <= ADDR_W'(tap.addr + 1);
        end else if (st == BG_TAIL) begin
            st        <= BG_IDLE;
            dq_valid  <= 1'b1;
            dq_rise   <= tail_base;
            dq_fall   <= ADDR_W'(tail_base + 1);
        end else begin
            dq_valid  <= 1'b0;
            dq_rise   <= '0;
            dq_fall   <= '0;
        end
    end

    assign pend = (st == BG_TAIL);

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
        pend |-> !tap.vld);

    assert_head_beat_R5: assert property (@(posedge clk) disable iff (rst)
        tap.vld |=> (dq_valid && dq_rise == $past(tap.addr)));

    assert_tail_follows_R5: assert property (@(posedge clk) disable iff (rst)
        pend |=> (dq_valid && dq_rise == ADDR_W'($past(dq_rise) + 2)));

endmodule

// File: rtl/rd_lat_pipe.sv
module rd_lat_pipe
    import rlp_pkg::*;
#(
    parameter int DEF_CL = 3,
    parameter int DEF_AL = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_word,
    input  logic [AL_W-1:0]   mode_al,
    input  logic              cmd_rd,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              dq_valid,
    output logic [ADDR_W-1:0] dq_rise,
    output logic [ADDR_W-1:0] dq_fall,
    output logic              req_err
);

    lat_cfg_t cfg;
    rd_tok_t  tap;
    logic     mode_rej;
    logic     head_vld;
    logic     any_vld;
    logic     pend;
    logic     busy;
    logic     rd_accept;
    logic     rd_drop;
    logic     unused_mode_bits;

    assign unused_mode_bits = ^{mode_word[MODE_W-1:CL_LSB+CL_CODE_W],
                                mode_word[CL_LSB-1:0]};

    assign rd_accept = cmd_rd && !head_vld;
    assign rd_drop   = cmd_rd && head_vld;
    assign busy      = cmd_rd || any_vld || pend;

    rlp_mode_reg #(
        .DEF_CL (DEF_CL),
        .DEF_AL (DEF_AL)
    ) u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr      (mode_wr),
        .cl_code (mode_word[CL_LSB +: CL_CODE_W]),
        .al_in   (mode_al),
        .busy    (busy),
        .cfg     (cfg),
        .rej     (mode_rej)
    );

    rlp_delay_line #(
        .DEPTH (LAT_MAX)
    ) u_line (
        .clk      (clk),
        .rst      (rst),
        .push     (rd_accept),
        .addr     (rd_addr),
        .tap_sel  (lat_total(cfg)),
        .tap      (tap),
        .head_vld (head_vld),
        .any_vld  (any_vld)
    );

    rlp_burst_gen u_burst (
        .clk      (clk),
        .rst      (rst),
        .tap      (tap),
        .dq_valid (dq_valid),
        .dq_rise  (dq_rise),
        .dq_fall  (dq_fall),
        .pend     (pend)
    );

    always_ff @(posedge clk) begin
        if (rst) req_err <= 1'b0;
        else     req_err <= mode_rej || rd_drop;
    end

    assert_err_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && busy) |=> req_err);

    assert_err_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_rd && head_vld) |=> req_err);

    assert_err_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!mode_wr && !cmd_rd) |=> !req_err);

endmodule

// File: tb/rd_lat_pipe_test.sv
module rd_lat_pipe_test;

    localparam int CLK_NS = 8;
    localparam int HIST   = 8192;

    logic        clk = 1'b0;
    logic        rst;
    logic        mode_wr;
    logic [12:0] mode_word;
    logic [2:0]  mode_al;
    logic        cmd_rd;
    logic [15:0] rd_addr;
    logic        dq_valid;
    logic [15:0] dq_rise;
    logic [15:0] dq_fall;
    logic        req_err;

    rd_lat_pipe uut (
        .clk       (clk),
        .rst       (rst),
        .mode_wr   (mode_wr),
        .mode_word (mode_word),
        .mode_al   (mode_al),
        .cmd_rd    (cmd_rd),
        .rd_addr   (rd_addr),
        .dq_valid  (dq_valid),
        .dq_rise   (dq_rise),
        .dq_fall   (dq_fall),
        .req_err   (req_err)
    );

    always #(CLK_NS/2) clk = ~clk;

    // {cl code [9:7], posted delay [6:4], read spacing [3:0]}
    localparam logic [9:0] VEC [20] = '{
        {3'd3, 3'd0, 4'd2}, {3'd3, 3'd1, 4'd3}, {3'd3, 3'd2, 4'd4}, {3'd3, 3'd3, 4'd5},
        {3'd3, 3'd4, 4'd2}, {3'd4, 3'd0, 4'd3}, {3'd4, 3'd1, 4'd4}, {3'd4, 3'd2, 4'd5},
        {3'd4, 3'd3, 4'd2}, {3'd4, 3'd4, 4'd3}, {3'd5, 3'd0, 4'd4}, {3'd5, 3'd1, 4'd5},
        {3'd5, 3'd2, 4'd2}, {3'd5, 3'd3, 4'd3}, {3'd5, 3'd4, 4'd4}, {3'd6, 3'd0, 4'd5},
        {3'd6, 3'd1, 4'd2}, {3'd6, 3'd2, 4'd3}, {3'd6, 3'd3, 4'd4}, {3'd6, 3'd4, 4'd5}
    };

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    mon_en = 0;
    bit    done = 0;
    string cur_req = "R1";
    int    m_cl = 3;
    int    m_al = 0;

    bit          exp_v   [HIST];
    logic [15:0] exp_r   [HIST];
    logic [15:0] exp_f   [HIST];
    bit          exp_err [HIST];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (mon_en && cyc < HIST) begin
            checks++;
            if (dq_valid !== exp_v[cyc] ||
                (exp_v[cyc] && (dq_rise !== exp_r[cyc] || dq_fall !== exp_f[cyc]))) begin
                fails++;
                $display("FAIL %s R5 cycle %0d: valid/rise/fall %b/%h/%h expected %b/%h/%h",
                         cur_req, cyc, dq_valid, dq_rise, dq_fall,
                         exp_v[cyc], exp_r[cyc], exp_f[cyc]);
            end
            checks++;
            if (req_err !== exp_err[cyc]) begin
                fails++;
                $display("FAIL %s R9 cycle %0d: req_err %b expected %b",
                         cur_req, cyc, req_err, exp_err[cyc]);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic mode_write(input logic [2:0] code, input logic [2:0] al, input bit busy);
        bit cl_good;
        bit al_good;
        cl_good   = (code >= 3'd3) && (code <= 3'd6);
        al_good   = (al <= 3'd4);
        mode_wr   = 1'b1;
        mode_word = {6'h2b, code, 4'h9};
        mode_al   = al;
        exp_err[cyc + 1] = busy || !cl_good || !al_good;
        if (!busy) begin
            if (cl_good) m_cl = int'(code);
            if (al_good) m_al = int'(al);
        end
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, input bit drop);
        int n;
        int rl;
        n  = cyc + 1;
        rl = m_cl + m_al;
        cmd_rd  = 1'b1;
        rd_addr = a;
        if (drop) begin
            exp_err[n] = 1'b1;
        end else begin
            exp_v[n + rl]     = 1'b1;
            exp_r[n + rl]     = a;
            exp_f[n + rl]     = a + 16'd1;
            exp_v[n + rl + 1] = 1'b1;
            exp_r[n + rl + 1] = a + 16'd2;
            exp_f[n + rl + 1] = a + 16'd3;
        end
        @(negedge clk);
        cmd_rd = 1'b0;
    endtask

    task automatic direct_check(input string req, input logic got, input logic want);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, got, want);
        end
    endtask

    initial begin
        for (int i = 0; i < HIST; i++) begin
            exp_v[i] = 0; exp_r[i] = '0; exp_f[i] = '0; exp_err[i] = 0;
        end
        rst = 1'b1; mode_wr = 0; mode_word = '0; mode_al = '0; cmd_rd = 0; rd_addr = '0;
        idle(3);
        direct_check("R1 reset dq_valid", dq_valid, 1'b0);
        direct_check("R1 reset req_err", req_err, 1'b0);
        rst = 1'b0;
        idle(1);
        mon_en = 1;

        // R1: default latency 3 + 0
        cur_req = "R1";
        do_read(16'h0100, 0);
        idle(14);

        // Table walk: every legal latency pair, several spacings (R2, R6)
        for (int t = 0; t < 20; t++) begin
            int gap;
            gap = int'(VEC[t][3:0]);
            cur_req = (gap == 2) ? "R6" : "R2";
            mode_write(VEC[t][9:7], VEC[t][6:4], 0);
            idle(1);
            for (int j = 0; j < 4; j++) begin
                do_read(16'(t * 16'h0400 + j * 16'h0010 + 3), 0);
                idle(gap - 1);
            end
            idle(14);
        end

        // R3: reserved codes keep the column latency (now 6)
        cur_req = "R3";
        mode_write(3'd7, 3'd0, 0);
        idle(1);
        mode_write(3'd2, 3'd1, 0);
        idle(1);
        do_read(16'h3000, 0);
        idle(14);

        // R4: posted delay above 4 keeps the old delay; legal code still applies
        cur_req = "R4";
        mode_write(3'd4, 3'd5, 0);
        idle(1);
        mode_write(3'd3, 3'd7, 0);
        idle(1);
        do_read(16'h4000, 0);
        idle(14);

        // R7: READ one clock after an accepted READ is dropped
        cur_req = "R7";
        mode_write(3'd5, 3'd2, 0);
        idle(1);
        do_read(16'h5000, 0);
        do_read(16'h5100, 1);
        idle(14);

        // R8: configuration write while a read is in flight is ignored
        cur_req = "R8";
        do_read(16'h6000, 0);
        idle(1);
        mode_write(3'd3, 3'd0, 1);
        idle(14);
        do_read(16'h6100, 0);
        idle(14);

        // R5: address wrap inside a burst
        cur_req = "R5";
        do_read(16'hfffe, 0);
        idle(14);

        // R9: quiet cycles, no error expected
        cur_req = "R9";
        idle(4);

        mon_en = 0;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule